// File: doc/BRIEF.md
# Packed Saturating Doubling Multiply-Accumulate-Long Unit

This block is a one-stage datapath for packed signed integers. It takes two 64-bit source vectors and one 128-bit accumulator vector. Each narrow source lane is multiplied by its partner, and the product is doubled and clamped to a signed value twice the lane width. That doubled product is then subtracted from, or added to, the matching wide accumulator lane, and that sum or difference is clamped as well. Both clamps feed one sticky saturation indicator. Outside logic clears the indicator through a dedicated input.

The lane width is 16 or 32 bits, which gives four or two lanes. A broadcast mode picks one element of the second source by index and uses it as the second operand in every lane. Results and the indicator are registered on a qualified clock edge, and a valid strobe comes out one cycle after the input strobe.

Top module: `satdbl_mac_long`

## Requirements
- R1: `lane32`=0 selects four 16-bit lanes and `lane32`=1 selects two 32-bit lanes. Narrow lane e occupies source bits [e*W +: W], and wide lane e occupies accumulator and result bits [e*2W +: 2W].
- R2: In each lane the doubled product 2*x*y is clamped to the signed 2W-bit range. This clamp happens only when both operands are -(2^(W-1)), and it yields 2^(2W-1)-1.
- R3: With `sub_mode`=1, each result lane equals the accumulator lane minus the clamped doubled product.
- R4: With `sub_mode`=0, each result lane equals the accumulator lane plus the clamped doubled product.
- R5: The sum or difference is formed at full precision and clamped to the signed 2W-bit range, giving -(2^(2W-1)) or 2^(2W-1)-1 and never a wrapped value.
- R6: With `bcast`=1, element `bidx` of `src_b` is the second operand in every lane. With 32-bit lanes only `bidx[0]` is used and `bidx[1]` is ignored. With `bcast`=0, lane e uses element e of `src_b`.
- R7: `sat_flag` becomes 1 on an accepted input in which any active lane clamps in either step, and it then stays 1 while `sat_clr` is low.
- R8: `sat_clr`=1 drives `sat_flag` to 0 on the next edge. If an accepted input clamps in that same cycle, `sat_flag` ends up 1.
- R9: `result` and `out_valid` update on the rising edge where `in_valid` is sampled. `out_valid` is 1 exactly one cycle after an accepted input, and `result` holds its value while `in_valid` is low.
- R10: A synchronous active-low reset sets `result` to 0, `out_valid` to 0 and `sat_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept the operands on this edge |
| lane32 | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| sub_mode | input | 1 | 1: subtract, 0: add |
| bcast | input | 1 | 1: broadcast one element of src_b |
| bidx | input | 2 | Element index used in broadcast mode |
| src_a | input | 64 | First narrow source vector |
| src_b | input | 64 | Second narrow source vector |
| acc_in | input | 128 | Wide accumulator vector |
| sat_clr | input | 1 | Clear the sticky saturation indicator |
| out_valid | output | 1 | Result register was loaded on the previous edge |
| result | output | 128 | Wide result vector |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
Faults in this block appear in the cycle right after an accepted input, because there is only one register stage. A wrong lane slice or a wrong broadcast selection corrupts one specific wide result lane. A clamp that is missing or inverted shows up as a wrapped value instead of an extreme value in a lane the bench drives to the boundary. A fault in the sticky logic shows on `sat_flag` either at that same edge or at the first later edge that is expected to keep or drop the flag.

// File: rtl/satmac_pkg.sv
// Shared widths for the saturating doubling multiply-accumulate-long unit.
// Assumes the narrow source vector is a whole multiple of both lane widths.
package satmac_pkg;
    localparam int SRC_W   = 64;
    localparam int ACC_W   = 2 * SRC_W;
    localparam int NW_S    = 16;
    localparam int NW_L    = 32;
    localparam int LANES_S = SRC_W / NW_S;
    localparam int LANES_L = SRC_W / NW_L;
    localparam int IDX_W   = $clog2(LANES_S);
endpackage

// File: rtl/satmac_opsel.sv
// Second-operand selector: in broadcast mode every lane receives element
// bidx of the source; otherwise lane e receives element e. Assumes the
// long-lane index is the low bits of bidx (upper bits ignored).
module satmac_opsel #(
    parameter int SRC_W = 64,
    parameter int NW_S  = 16,
    parameter int NW_L  = 32,
    parameter int IDX_W = 2,
    localparam int LS   = SRC_W / NW_S,
    localparam int LL   = SRC_W / NW_L,
    localparam int IL_W = (LL > 1) ? $clog2(LL) : 1
) (
    input  logic [SRC_W-1:0]           src,
    input  logic                       bcast,
    input  logic [IDX_W-1:0]           bidx,
    output logic [LS-1:0][NW_S-1:0]    op_s,
    output logic [LL-1:0][NW_L-1:0]    op_l
);
    logic [LS-1:0][NW_S-1:0] el_s;
    logic [LL-1:0][NW_L-1:0] el_l;
    logic [IL_W-1:0]         idx_l;

    assign el_s  = src;
    assign el_l  = src;
    assign idx_l = bidx[IL_W-1:0];

    for (genvar e = 0; e < LS; e++) begin : g_s
        // pick own element or the broadcast element for a short lane
        assign op_s[e] = bcast ? el_s[bidx] : el_s[e];
    end
    for (genvar e = 0; e < LL; e++) begin : g_l
        // pick own element or the broadcast element for a long lane
        assign op_l[e] = bcast ? el_l[idx_l] : el_l[e];
    end
endmodule

// File: rtl/satmac_lane.sv
// One lane: clamped doubling multiply, then a clamped accumulate of width
// 2*NW. Purely combinational; reports each clamp separately.
module satmac_lane #(
    parameter int NW = 16,
    localparam int WW = 2 * NW
) (
    input  logic [NW-1:0] x,
    input  logic [NW-1:0] y,
    input  logic [WW-1:0] acc,
    input  logic          sub,
    output logic [WW-1:0] res,
    output logic          sat_dbl,
    output logic          sat_acc
);
    localparam logic [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
    localparam logic [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};
    localparam logic [NW-1:0] NMIN = {1'b1, {(NW-1){1'b0}}};

    logic signed [WW-1:0] prod;
    logic        [WW:0]   dbl_full;
    logic        [WW-1:0] dbl;
    logic        [WW:0]   acc_x;
    logic        [WW:0]   dbl_x;
    logic        [WW:0]   total;

    // exact signed product and its double one bit wider
    always_comb begin
        prod     = $signed(x) * $signed(y);
        dbl_full = {prod, 1'b0};
        sat_dbl  = dbl_full[WW] ^ dbl_full[WW-1];
        dbl      = sat_dbl ? (dbl_full[WW] ? WMIN : WMAX) : dbl_full[WW-1:0];
    end

    // full-precision accumulate, then clamp to the wide range
    always_comb begin
        acc_x   = {acc[WW-1], acc};
        dbl_x   = {dbl[WW-1], dbl};
        total   = sub ? (acc_x - dbl_x) : (acc_x + dbl_x);
        sat_acc = total[WW] ^ total[WW-1];
        res     = sat_acc ? (total[WW] ? WMIN : WMAX) : total[WW-1:0];
    end

    // guard the clamp conditions
    always_comb begin
        // R2
        dbl_only_min_chk: assert (!sat_dbl || (x == NMIN && y == NMIN));
        // R5
        acc_extreme_chk: assert (!sat_acc || res == WMAX || res == WMIN);
    end
endmodule

// File: rtl/satdbl_mac_long.sv
// Top: packed saturating doubling multiply-accumulate-long with one
// register stage and a sticky saturation indicator. Both lane widths are
// computed every cycle and lane32 picks one; assumes 64-bit sources.
module satdbl_mac_long
    import satmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              lane32,
    input  logic              sub_mode,
    input  logic              bcast,
    input  logic [IDX_W-1:0]  bidx,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [SRC_W-1:0]  src_b,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [ACC_W-1:0]  result,
    output logic              sat_flag
);
    localparam int WS = 2 * NW_S;
    localparam int WL = 2 * NW_L;

    logic [LANES_S-1:0][NW_S-1:0] a_s, b_s;
    logic [LANES_L-1:0][NW_L-1:0] a_l, b_l;
    logic [LANES_S-1:0][WS-1:0]   acc_s, res_s;
    logic [LANES_L-1:0][WL-1:0]   acc_l, res_l;
    logic [LANES_S-1:0]           sd_s, sa_s;
    logic [LANES_L-1:0]           sd_l, sa_l;
    logic [ACC_W-1:0]             nxt_res;
    logic                         any_sat;

    assign a_s   = src_a;
    assign a_l   = src_a;
    assign acc_s = acc_in;
    assign acc_l = acc_in;

    satmac_opsel #(
        .SRC_W(SRC_W), .NW_S(NW_S), .NW_L(NW_L), .IDX_W(IDX_W)
    ) u_sel (
        .src(src_b), .bcast(bcast), .bidx(bidx), .op_s(b_s), .op_l(b_l)
    );

    for (genvar e = 0; e < LANES_S; e++) begin : g_ls
        satmac_lane #(.NW(NW_S)) u_lane (
            .x(a_s[e]), .y(b_s[e]), .acc(acc_s[e]), .sub(sub_mode),
            .res(res_s[e]), .sat_dbl(sd_s[e]), .sat_acc(sa_s[e])
        );
    end
    for (genvar e = 0; e < LANES_L; e++) begin : g_ll
        satmac_lane #(.NW(NW_L)) u_lane (
            .x(a_l[e]), .y(b_l[e]), .acc(acc_l[e]), .sub(sub_mode),
            .res(res_l[e]), .sat_dbl(sd_l[e]), .sat_acc(sa_l[e])
        );
    end

    // choose the active lane width and merge its clamp reports
    always_comb begin
        nxt_res = lane32 ? res_l : res_s;
        any_sat = lane32 ? (|sd_l | |sa_l) : (|sd_s | |sa_s);
    end

    // register results, strobe and sticky indicator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt_res;
            sat_flag  <= (sat_flag & ~sat_clr) | (in_valid & any_sat);
        end
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R7
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);
    // R8
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !in_valid) |=> !sat_flag);
endmodule

// File: tb/sim_satdbl_mac_long.sv
module sim_satdbl_mac_long;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, lane32 = 1'b0, sub_mode = 1'b0, bcast = 1'b0;
    logic [1:0]   bidx = '0;
    logic [63:0]  src_a = '0, src_b = '0;
    logic [127:0] acc_in = '0;
    logic         sat_clr = 1'b0;
    logic         out_valid, sat_flag;
    logic [127:0] result;

    int n_chk = 0, n_err = 0;
    logic         exp_flag = 1'b0;

    always #4 clk = ~clk;

    satdbl_mac_long u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane32(lane32),
        .sub_mode(sub_mode), .bcast(bcast), .bidx(bidx), .src_a(src_a),
        .src_b(src_b), .acc_in(acc_in), .sat_clr(sat_clr),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    typedef struct packed {
        logic         l32;
        logic         sub;
        logic         bc;
        logic [1:0]   ix;
        logic [63:0]  a;
        logic [63:0]  b;
        logic [127:0] acc;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b0, 1'b1, 1'b0, 2'd0, 64'h0003_FFFE_0100_7FFF, 64'h0002_0005_FF00_0001,
          128'h00000010_00000000_00010000_00000005},
        '{1'b0, 1'b0, 1'b0, 2'd0, 64'h1234_8001_0007_FFF9, 64'h0010_7FFF_FFF3_0008,
          128'h7FFF0000_00000100_FFFFFFF0_12345678},
        '{1'b0, 1'b1, 1'b0, 2'd0, 64'h0001_0002_0003_8000, 64'h7FFF_8000_0004_8000,
          128'h00000000_00000000_00000000_00000000},
        '{1'b1, 1'b0, 1'b0, 2'd0, 64'h7FFFFFFF_00000003, 64'h7FFFFFFF_00000004,
          128'h7FFFFFFF_00000000_7FFFFFFF_FFFFFFF0},
        '{1'b1, 1'b1, 1'b1, 2'd3, 64'hFFFFFFFE_00001000, 64'h00000003_DEADBEEF,
          128'h00000000_00001000_FFFFFFFF_00000000},
        '{1'b0, 1'b0, 1'b1, 2'd2, 64'h0001_FFFF_0002_0003, 64'h1111_0005_2222_3333,
          128'h00000001_00000002_00000003_00000004},
        '{1'b1, 1'b1, 1'b0, 2'd0, 64'h00000005_40000000, 64'h00000002_7FFFFFFF,
          128'h00000000_00000000_80000000_00000001},
        '{1'b1, 1'b0, 1'b0, 2'd0, 64'hFFFF0000_00012345, 64'h00000100_FFFFFFFE,
          128'h01234567_89ABCDEF_00000000_00000064}
    };

    // reference model written from R1..R6; returns result and clamp flag
    function automatic void ref_calc(input vec_t v, output logic [127:0] r, output logic s);
        logic signed [67:0] x, y, p, ac, t, pmax, pmin;
        int nl, w;
        s  = 1'b0;
        r  = '0;
        w  = v.l32 ? 32 : 16;
        nl = 64 / w;
        pmax = (68'sd1 <<< (2*w-1)) - 1;
        pmin = -(68'sd1 <<< (2*w-1));
        for (int e = 0; e < nl; e++) begin
            int k;
            k = v.bc ? (v.l32 ? int'(v.ix[0]) : int'(v.ix)) : e;
            if (v.l32) begin
                x  = 68'($signed(v.a[e*32 +: 32]));
                y  = 68'($signed(v.b[k*32 +: 32]));
                ac = 68'($signed(v.acc[e*64 +: 64]));
            end else begin
                x  = 68'($signed(v.a[e*16 +: 16]));
                y  = 68'($signed(v.b[k*16 +: 16]));
                ac = 68'($signed(v.acc[e*32 +: 32]));
            end
            p = 2 * x * y;
            if (p > pmax) begin p = pmax; s = 1'b1; end
            t = v.sub ? ac - p : ac + p;
            if (t > pmax) begin t = pmax; s = 1'b1; end
            if (t < pmin) begin t = pmin; s = 1'b1; end
            if (v.l32) r[e*64 +: 64] = t[63:0];
            else       r[e*32 +: 32] = t[31:0];
        end
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one accepted input, sample after the capturing edge
    task automatic apply(input vec_t v, input logic clr);
        @(negedge clk);
        in_valid = 1'b1; lane32 = v.l32; sub_mode = v.sub; bcast = v.bc;
        bidx = v.ix; src_a = v.a; src_b = v.b; acc_in = v.acc; sat_clr = clr;
        @(posedge clk); #1;
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [127:0] er;
        logic         es;
        vec_t         v;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 result", result, '0);
        chk("R10 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R10 sat_flag", {127'd0, sat_flag}, 128'd0);
        @(negedge clk); rst_n = 1'b1;

        // table walk: R1..R7
        for (int i = 0; i < 8; i++) begin
            ref_calc(TBL[i], er, es);
            exp_flag = exp_flag | es;
            apply(TBL[i], 1'b0);
            chk($sformatf("R1/R3/R4/R5/R6 vec%0d result", i), result, er);
            chk($sformatf("R7 vec%0d sat_flag", i), {127'd0, sat_flag}, {127'd0, exp_flag});
        end

        // R9: out_valid drops and result holds while idle
        er = result;
        @(negedge clk);
        chk("R9 out_valid idle", {127'd0, out_valid}, 128'd0);
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; acc_in = '1;
        @(posedge clk); #1;
        chk("R9 result held", result, er);

        // R8: clear with no event
        @(negedge clk); sat_clr = 1'b1;
        @(posedge clk); #1;
        chk("R8 clear", {127'd0, sat_flag}, 128'd0);
        @(negedge clk); sat_clr = 1'b0;

        // R2 directed: 16-bit min*min, subtract from zero
        v = '{1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 128'd0};
        apply(v, 1'b1);
        chk("R2 min*min lane0", result, 128'h00000000_00000000_00000000_80000001);
        chk("R8 clear plus event", {127'd0, sat_flag}, 128'd1);

        // R7: no-clamp input keeps the flag
        v = '{1'b0, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0003, 128'd1};
        apply(v, 1'b0);
        chk("R4 small add", result, 128'd13);
        chk("R7 sticky", {127'd0, sat_flag}, 128'd1);

        // R5: 32-bit add clamps to positive max, R6 bidx[1] ignored
        v = '{1'b1, 1'b0, 1'b1, 2'd2, 64'h00000001_7FFFFFFF, 64'h00000002_7FFFFFFF,
              128'h7FFFFFFF_FFFFFFFF_00000000_00000000};
        apply(v, 1'b1);
        chk("R5/R6 32-bit broadcast clamp", result,
            128'h7FFFFFFF_FFFFFFFF_7FFFFFFE_00000002);
        chk("R8 clear plus event 32", {127'd0, sat_flag}, 128'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule